// File: doc/BRIEF.md
# Clock Rate Controller with Automatic Full-Speed Return

This block paces a processor core and its peripherals from a single oscillator clock. It emits a one-cycle clock-enable pulse once per divided period. Software chooses among three rates through a small write port. At full speed the period is 4 oscillator cycles. A medium-power rate stretches the period to 64 cycles, and a deep low-power rate stretches it to 1024 cycles.

Two hardware events can bring the block back to full speed with no software involved. The first is an interrupt acknowledge, and the second is a falling edge on the serial receive line, which marks the start bit of an incoming frame. Each event has its own enable input. When an enabled event is seen, the stored rate is cleared to full speed and a sticky "woken" flag is raised. The slow period that is running is then cut at the next 4-cycle slot, so the rest of a serial frame is handled at full speed. A change of rate made by software waits for the end of the period that is running. A status output reports the rate that is actually in force.

Top module: `clk_rate_ctrl`

## Requirements
- R1: After reset, `rate_o` is 2'b00, `woke_o` is 0 and `tick_o` is low. The first `tick_o` comes in the 4th cycle after reset is released. At full speed `tick_o` is one cycle wide and repeats every 4 cycles.
- R2: The rate field is `cfg_wdata_i[1:0]`, written when `cfg_we_i` is high. Code 2'b01 gives a 64-cycle tick period and code 2'b10 gives a 1024-cycle period, and `rate_o` reports the code in force.
- R3: Code 2'b11 acts as full speed. It gives a 4-cycle period, and `rate_o` then reads 2'b00.
- R4: A written rate takes effect only at the boundary that ends the period in progress. That period keeps its full length, and `rate_o` changes only in the cycle after a tick.
- R5: With `irq_ret_en_i` high, an `irq_ack_i` pulse sets `woke_o` in the next cycle and clears the stored rate to full speed. The slow period ends with a tick in the first later cycle whose position in the period is a multiple of 4, and 4-cycle periods follow.
- R6: With `rx_ret_en_i` high, a falling edge on `rx_i` passes through a 2-flop synchronizer and then has the same effect as R5. `woke_o` rises 3 cycles after the edge is sampled.
- R7: While its enable is low, an acknowledge or receive edge has no effect: the slow period runs its full length, the rate is kept and `woke_o` stays 0.
- R8: When an enabled return event comes in the same cycle as a write of a low-power code, the event wins: the rate becomes full speed and `woke_o` is set.
- R9: A write with `cfg_wdata_i[2]` = 1 clears `woke_o`. A write with that bit 0 leaves it unchanged.
- R10: Two ticks are never closer together than 4 cycles, including the early tick of R5 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | [1:0] rate code, [2] write 1 to clear the woken flag |
| irq_ack_i | input | 1 | Interrupt acknowledge strobe |
| irq_ret_en_i | input | 1 | Enables return to full speed on an acknowledge |
| rx_i | input | 1 | Serial receive line (idles high) |
| rx_ret_en_i | input | 1 | Enables return to full speed on a receive start edge |
| tick_o | output | 1 | Clock-enable pulse, one cycle per divided period |
| rate_o | output | 2 | Rate in force: 00 full, 01 medium, 10 deep |
| woke_o | output | 1 | Sticky flag: a hardware return to full speed occurred |

## Verification
A corrupt period counter or active-rate register shows up on `tick_o`. The spacing between ticks is wrong within one period, so a fault can take up to 1024 cycles to appear in deep mode. For this reason the tests measure whole periods tick to tick, and they also measure the partial period in which a write arrives. A stored rate that fails to clear on a return event is seen at `rate_o` one cycle after the early tick. A flag fault is seen at `woke_o` one cycle after the event or the clearing write. The receive path is timed against its fixed synchronizer delay, so an extra or missing stage moves the early tick by a cycle and is caught.

// File: rtl/clk_rate_pkg.sv
`timescale 1ns/1ps
package clk_rate_pkg;

  typedef enum logic [1:0] {
    RATE_FULL = 2'b00,
    RATE_MID  = 2'b01,
    RATE_DEEP = 2'b10,
    RATE_RSVD = 2'b11
  } rate_e;

  // Map a raw rate code onto a code that can be in force; reserved runs fast.
  function automatic rate_e rate_legal(input logic [1:0] code);
    rate_e r;
    if (code == 2'b11) r = RATE_FULL;
    else               r = rate_e'(code);
    return r;
  endfunction

endpackage

// File: rtl/rx_fall_det.sv
`timescale 1ns/1ps
module rx_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_d;

  // Shift chain: SYNC_STAGES synchronizer flops plus one history flop.
  always_comb begin
    sh_d = {sh_q[SH_W-2:0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= sh_d;
  end

  assign fall_o = sh_q[SH_W-1] & ~sh_q[SH_W-2];

endmodule

// File: rtl/rate_mode_reg.sv
`timescale 1ns/1ps
module rate_mode_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] wdata_i,
  input  logic       wake_i,
  output logic [1:0] req_d_o,
  output logic       flag_o
);

  logic [1:0] req_q;
  logic [1:0] req_d;
  logic       flag_q;
  logic       flag_d;

  // Hardware return outranks a software write in the same cycle.
  always_comb begin
    req_d = req_q;
    if (wake_i)    req_d = 2'b00;
    else if (we_i) req_d = wdata_i[1:0];
  end

  // Event sets; write-one clears; setting wins.
  always_comb begin
    flag_d = flag_q;
    if (wake_i)                 flag_d = 1'b1;
    else if (we_i && wdata_i[2]) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 2'b00;
      flag_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      flag_q <= flag_d;
    end
  end

  assign req_d_o = req_d;
  assign flag_o  = flag_q;

endmodule

// File: rtl/rate_divider.sv
`timescale 1ns/1ps
module rate_divider
  import clk_rate_pkg::*;
#(
  parameter int FULL_LOG2 = 2,
  parameter int MID_LOG2  = 6,
  parameter int DEEP_LOG2 = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_next_i,
  input  logic       wake_i,
  output logic       tick_o,
  output logic [1:0] act_o
);

  localparam int CNT_W = DEEP_LOG2;
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'((1 << FULL_LOG2) - 1);
  localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'((1 << MID_LOG2) - 1);
  localparam logic [CNT_W-1:0] DEEP_LAST = CNT_W'((1 << DEEP_LOG2) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last;
  rate_e            act_q;
  rate_e            act_d;
  logic             pend_q;
  logic             pend_d;
  logic             slot_end;
  logic             tick;

  always_comb begin
    unique case (act_q)
      RATE_MID:  last = MID_LAST;
      RATE_DEEP: last = DEEP_LAST;
      default:   last = FULL_LAST;
    endcase
  end

  // A pending return cuts the period at the next full-speed slot end.
  assign slot_end = &cnt_q[FULL_LOG2-1:0];
  assign tick     = (cnt_q == last) | (pend_q & slot_end);

  always_comb begin
    cnt_d  = cnt_q + CNT_W'(1);
    act_d  = act_q;
    pend_d = pend_q;
    if (tick) begin
      cnt_d  = '0;
      act_d  = rate_legal(req_next_i);
      pend_d = 1'b0;
    end
    if (wake_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      act_q  <= RATE_FULL;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  assign tick_o = tick;
  assign act_o  = act_q;

endmodule

// File: rtl/clk_rate_ctrl.sv
`timescale 1ns/1ps
module clk_rate_ctrl
  import clk_rate_pkg::*;
#(
  parameter int FULL_LOG2   = 2,
  parameter int MID_LOG2    = 6,
  parameter int DEEP_LOG2   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [2:0] cfg_wdata_i,
  input  logic       irq_ack_i,
  input  logic       irq_ret_en_i,
  input  logic       rx_i,
  input  logic       rx_ret_en_i,
  output logic       tick_o,
  output logic [1:0] rate_o,
  output logic       woke_o
);

  logic       rx_fall;
  logic       wake;
  logic [1:0] req_next;

  rx_fall_det #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_rx_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .fall_o(rx_fall)
  );

  assign wake = (irq_ack_i & irq_ret_en_i) | (rx_fall & rx_ret_en_i);

  rate_mode_reg i_mode_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .wake_i (wake),
    .req_d_o(req_next),
    .flag_o (woke_o)
  );

  rate_divider #(
    .FULL_LOG2(FULL_LOG2),
    .MID_LOG2 (MID_LOG2),
    .DEEP_LOG2(DEEP_LOG2)
  ) i_divider (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_next_i(req_next),
    .wake_i    (wake),
    .tick_o    (tick_o),
    .act_o     (rate_o)
  );

endmodule

// File: rtl/clk_rate_ctrl_chk.sv
`timescale 1ns/1ps
module clk_rate_ctrl_chk #(
  parameter int FULL_LOG2 = 2,
  parameter int DEEP_LOG2 = 10
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_o,
  input logic [1:0] rate_o,
  input logic       woke_o,
  input logic       irq_ack_i,
  input logic       irq_ret_en_i,
  input logic       rx_i,
  input logic       rx_ret_en_i
);

  localparam int GAP_W   = DEEP_LOG2 + 1;
  localparam int MIN_GAP = (1 << FULL_LOG2) - 1;
  localparam int MAX_GAP = (1 << DEEP_LOG2) - 1;

  logic [GAP_W-1:0] gap_q;

  // Cycles since the last tick, saturating.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= '0;
    else if (tick_o)      gap_q <= '0;
    else if (~&gap_q)     gap_q <= gap_q + GAP_W'(1);
  end

  p_min_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (int'(gap_q) >= MIN_GAP));

  p_max_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(gap_q) <= MAX_GAP);

  p_legal_rate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_o != 2'b11);

  p_boundary_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_o != $past(rate_o)) |-> $past(tick_o));

  p_irq_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_ret_en_i) |=> woke_o);

  // Assumes the receive enable is held while the edge crosses the synchronizer.
  p_rx_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rx_i) && rx_ret_en_i) |-> ##3 woke_o);

endmodule

bind clk_rate_ctrl clk_rate_ctrl_chk #(
  .FULL_LOG2(FULL_LOG2),
  .DEEP_LOG2(DEEP_LOG2)
) i_clk_rate_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_o      (tick_o),
  .rate_o      (rate_o),
  .woke_o      (woke_o),
  .irq_ack_i   (irq_ack_i),
  .irq_ret_en_i(irq_ret_en_i),
  .rx_i        (rx_i),
  .rx_ret_en_i (rx_ret_en_i)
);

// File: tb/test_clk_rate_ctrl.sv
`timescale 1ns/1ps
module test_clk_rate_ctrl;

  logic       clk;
  logic       rst_n;
  logic       we;
  logic [2:0] wdata;
  logic       ack;
  logic       irq_en;
  logic       rx;
  logic       rx_en;
  logic       tick;
  logic [1:0] rate;
  logic       woke;

  int n_run;
  int n_fail;
  bit finished;

  clk_rate_ctrl i_clk_rate_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (we),
    .cfg_wdata_i (wdata),
    .irq_ack_i   (ack),
    .irq_ret_en_i(irq_en),
    .rx_i        (rx),
    .rx_ret_en_i (rx_en),
    .tick_o      (tick),
    .rate_o      (rate),
    .woke_o      (woke)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Advance to the next negedge on which tick is high; n counts negedges.
  task automatic to_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 3000);
  endtask

  task automatic cfg(input logic [2:0] d);
    we    = 1'b1;
    wdata = d;
    @(negedge clk);
    we    = 1'b0;
    wdata = 3'b000;
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    chk(tick == 1'b0, "R1 tick in reset", tick, 0);
    chk(rate == 2'b00, "R1 rate after reset", rate, 0);
    chk(woke == 1'b0, "R1 flag after reset", woke, 0);
    to_tick(n);
    chk(n == 3, "R1 first tick position", n, 3);
    to_tick(n);
    chk(n == 4, "R1 full period", n, 4);
    step();
    chk(tick == 1'b0, "R1 tick width", tick, 0);
  endtask

  task automatic t_mid_deep();
    int n;
    to_tick(n);
    cfg(3'b001);
    chk(rate == 2'b01, "R2 medium code in force", rate, 1);
    to_tick(n);
    chk(n == 63, "R2 first medium period", n, 63);
    to_tick(n);
    chk(n == 64, "R2 medium period", n, 64);
    cfg(3'b010);
    to_tick(n);
    chk(n == 1023, "R2 deep period", n, 1023);
    chk(rate == 2'b10, "R2 deep code in force", rate, 2);
  endtask

  task automatic t_reserved();
    int n;
    cfg(3'b011);
    chk(rate == 2'b00, "R3 reserved reads full", rate, 0);
    to_tick(n);
    to_tick(n);
    chk(n == 4, "R3 reserved period", n, 4);
  endtask

  task automatic t_boundary();
    int n;
    cfg(3'b001);
    to_tick(n);
    chk(n == 63, "R4 medium after write", n, 63);
    repeat (11) step();
    cfg(3'b010);
    chk(rate == 2'b01, "R4 rate held mid-period", rate, 1);
    to_tick(n);
    chk(n == 52, "R4 period kept full length", n, 52);
    step();
    chk(rate == 2'b10, "R4 rate after boundary", rate, 2);
    to_tick(n);
    chk(n == 1023, "R4 new period length", n, 1023);
  endtask

  task automatic t_irq_return();
    int n;
    repeat (6) step();
    irq_en = 1'b1;
    ack    = 1'b1;
    step();
    ack    = 1'b0;
    chk(woke == 1'b1, "R5 flag after acknowledge", woke, 1);
    to_tick(n);
    chk(n == 1, "R5 early tick slot", n, 1);
    step();
    chk(rate == 2'b00, "R5 rate after return", rate, 0);
    to_tick(n);
    to_tick(n);
    chk(n == 4, "R10 period after return", n, 4);
    irq_en = 1'b0;
  endtask

  task automatic t_flag_clear();
    cfg(3'b000);
    chk(woke == 1'b1, "R9 flag kept on bit2=0", woke, 1);
    cfg(3'b100);
    chk(woke == 1'b0, "R9 flag cleared on bit2=1", woke, 0);
  endtask

  task automatic t_rx_return();
    int n;
    cfg(3'b010);
    to_tick(n);
    to_tick(n);
    chk(n == 1024, "R6 deep period before edge", n, 1024);
    rx_en = 1'b1;
    repeat (5) step();
    rx = 1'b0;
    to_tick(n);
    chk(n == 3, "R6 early tick after sync delay", n, 3);
    chk(woke == 1'b1, "R6 flag after start edge", woke, 1);
    rx = 1'b1;
    step();
    chk(rate == 2'b00, "R6 rate after return", rate, 0);
    rx_en = 1'b0;
  endtask

  task automatic t_disabled();
    int n;
    cfg(3'b110);
    to_tick(n);
    to_tick(n);
    chk(n == 1024, "R7 deep period set", n, 1024);
    repeat (10) step();
    ack = 1'b1;
    step();
    ack = 1'b0;
    rx  = 1'b0;
    repeat (4) step();
    rx  = 1'b1;
    to_tick(n);
    chk(n == 1009, "R7 period not cut", n, 1009);
    chk(woke == 1'b0, "R7 flag untouched", woke, 0);
    chk(rate == 2'b10, "R7 rate kept", rate, 2);
  endtask

  task automatic t_priority();
    int n;
    irq_en = 1'b1;
    we     = 1'b1;
    wdata  = 3'b001;
    ack    = 1'b1;
    step();
    we     = 1'b0;
    wdata  = 3'b000;
    ack    = 1'b0;
    irq_en = 1'b0;
    chk(woke == 1'b1, "R8 flag set", woke, 1);
    chk(rate == 2'b00, "R8 rate full", rate, 0);
    to_tick(n);
    to_tick(n);
    chk(n == 4, "R8 full period kept", n, 4);
    to_tick(n);
    chk(n == 4, "R8 no medium rate", n, 4);
  endtask

  initial begin
    n_run    = 0;
    n_fail   = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    we       = 1'b0;
    wdata    = 3'b000;
    ack      = 1'b0;
    irq_en   = 1'b0;
    rx       = 1'b1;
    rx_en    = 1'b0;
    t_reset();
    t_mid_deep();
    t_reserved();
    t_boundary();
    t_irq_return();
    t_flag_clear();
    t_rx_return();
    t_disabled();
    t_priority();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule